// File: doc/BRIEF.md
# Host bridge I/O window decoder

This block sits between a CPU request port and the buses below a host bridge. It looks at each CPU access and sorts it into one of four kinds. An access in the I/O aperture is sent to a downstream I/O port at a translated port address. An access in the configuration window is sent to a configuration port as an offset. A single-byte read of the interrupt-acknowledge location returns the vector supplied by an external interrupt controller. Every other access gets an error response. Each access produces exactly one response, and at most one downstream transaction.

A one-bit map-mode register, written by the system-control bus, picks the I/O translation. In flat mode the aperture folds onto a 64 KB port space. In sparse mode each 4 KB page of the CPU window carries one 32-byte group of ports. The block also routes device interrupt pins onto two interrupt lines by slot.

Top module: `hbio_bridge`

## Requirements
- R1: After reset the map mode is flat, `cpu_ready_o` is 1, and `io_valid_o`, `cfg_valid_o` and `cpu_resp_o` are 0.
- R2: In flat mode, an access to the aperture 0x80000000–0x807FFFFF is issued on the I/O port at address 0x80000000 | cpu_addr[15:0].
- R3: In sparse mode, the I/O port address is 0x80000000 | (cpu_addr[22:12] << 5) | cpu_addr[4:0].
- R4: A write on the system-control bus to port 0x850 loads bit 0 of `sys_wdata_i` into the map mode (0 flat, 1 sparse). A write to any other port leaves the mode unchanged.
- R5: A mode change made while an access is in flight does not alter that access. It applies from the next accepted request.
- R6: `cpu_size_i` gives the byte count. Sizes 1, 2 and 4 are legal at any alignment, and the address is passed through unchanged. Any other size gets an error response and issues no downstream transaction.
- R7: Data is little-endian and lane-aligned. Write data is forwarded unchanged on `dn_wdata_o`. Read data keeps only the low `cpu_size_i` bytes of the downstream data, and the upper bytes are zero.
- R8: An access to 0x80800000–0x80BFFFFF goes to the configuration port, with `cfg_addr_o` set to cpu_addr[21:0].
- R9: A 1-byte read of 0xBFFFFFF0 returns `intack_vec_i` zero-extended and pulses `intack_ack_o` with the response. A write there, or any other size, gets an error response.
- R10: An access outside all windows gets an error response and issues no downstream transaction.
- R11: Each access issues at most one downstream transaction. The request holds address and data stable until ready. The response comes only after the downstream handshake, two cycles after acceptance plus the number of ready wait cycles.
- R12: Pin p (0..3) of slot s drives `irq_o[(p+s) mod 2]`. This pin is bit s*4+p of `pci_int_i`, and each line is the OR of its pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | CPU request valid |
| cpu_ready_o | output | 1 | Block can accept a request |
| cpu_addr_i | input | 32 | CPU byte address |
| cpu_size_i | input | 3 | Byte count |
| cpu_we_i | input | 1 | 1 for write |
| cpu_wdata_i | input | 32 | Write data, little-endian lanes |
| cpu_resp_o | output | 1 | Response strobe, one cycle |
| cpu_err_o | output | 1 | Error flag with response |
| cpu_rdata_o | output | 32 | Read data with response |
| io_valid_o | output | 1 | I/O request valid |
| io_ready_i | input | 1 | I/O request accepted |
| io_addr_o | output | 32 | Translated I/O address |
| io_rdata_i | input | 32 | I/O read data |
| cfg_valid_o | output | 1 | Configuration request valid |
| cfg_ready_i | input | 1 | Configuration request accepted |
| cfg_addr_o | output | 22 | Offset in configuration window |
| cfg_rdata_i | input | 32 | Configuration read data |
| dn_size_o | output | 3 | Byte count for downstream request |
| dn_we_o | output | 1 | Write flag for downstream request |
| dn_wdata_o | output | 32 | Write data for downstream request |
| intack_vec_i | input | 8 | Pending interrupt vector |
| intack_ack_o | output | 1 | Vector consumed strobe |
| sys_wr_i | input | 1 | System-control byte write strobe |
| sys_port_i | input | 16 | System-control port number |
| sys_wdata_i | input | 8 | System-control write byte |
| pci_int_i | input | 16 | Device pins, bit s*4+p |
| irq_o | output | 2 | Swizzled interrupt lines |

## Verification
The handshake assertions assume the I/O and configuration targets return ready only while a request is valid. They also assume the CPU side holds no request while a response is pending. The bench's responders raise ready for exactly one cycle per request, after a programmed wait count. The CPU task drives one request at a time and waits for its response. Mode writes arrive on the system-control bus alone, sometimes in the middle of a pending I/O access, and never as a CPU access.

// File: rtl/hbio_pkg.sv
package hbio_pkg;
  typedef enum logic [1:0] {
    K_IO  = 2'd0,
    K_CFG = 2'd1,
    K_ACK = 2'd2,
    K_ERR = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IO   = 2'd1,
    ST_CFG  = 2'd2,
    ST_RESP = 2'd3
  } state_e;
endpackage

// File: rtl/hbio_mode_reg.sv
module hbio_mode_reg #(
  parameter int          PORT_W    = 16,
  parameter logic [15:0] MODE_PORT = 16'h0850
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_wr_i,
  input  logic [PORT_W-1:0] sys_port_i,
  input  logic [7:0]        sys_wdata_i,
  output logic              mode_o
);
  logic mode_q;
  logic hit;

  assign hit = sys_wr_i && (sys_port_i == MODE_PORT[PORT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mode_q <= 1'b0;
    else if (hit) mode_q <= sys_wdata_i[0];
  end

  assign mode_o = mode_q;

  assert_mode_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> mode_q == $past(sys_wdata_i[0]));
  assert_mode_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(mode_q));
endmodule

// File: rtl/hbio_decode.sv
module hbio_decode
  import hbio_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          PORT_W      = 16,
  parameter int          OFS_W       = 5,
  parameter int          PAGE_LSB    = 12,
  parameter int          IO_SPAN_L2  = 23,
  parameter int          CFG_SPAN_L2 = 22,
  parameter logic [31:0] IO_BASE     = 32'h8000_0000,
  parameter logic [31:0] CFG_BASE    = 32'h8080_0000,
  parameter logic [31:0] ACK_ADDR    = 32'hBFFF_FFF0
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [2:0]             size_i,
  input  logic                   we_i,
  input  logic                   mode_i,
  output kind_e                  kind_o,
  output logic [ADDR_W-1:0]      io_addr_o,
  output logic [CFG_SPAN_L2-1:0] cfg_off_o
);
  localparam int GRP_W = PORT_W - OFS_W;

  logic              size_ok;
  logic              in_io, in_cfg, in_ack;
  logic [PORT_W-1:0] port_flat, port_sparse, port;

  assign size_ok = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
  assign in_io   = (addr_i >> IO_SPAN_L2)  == (ADDR_W'(IO_BASE)  >> IO_SPAN_L2);
  assign in_cfg  = (addr_i >> CFG_SPAN_L2) == (ADDR_W'(CFG_BASE) >> CFG_SPAN_L2);
  assign in_ack  = addr_i == ADDR_W'(ACK_ADDR);

  assign port_flat   = addr_i[PORT_W-1:0];
  assign port_sparse = {addr_i[PAGE_LSB +: GRP_W], addr_i[OFS_W-1:0]};
  assign port        = mode_i ? port_sparse : port_flat;

  assign io_addr_o = ADDR_W'(IO_BASE) | ADDR_W'(port);
  assign cfg_off_o = addr_i[CFG_SPAN_L2-1:0];

  always_comb begin
    if (!size_ok)                                kind_o = K_ERR;
    else if (in_io)                              kind_o = K_IO;
    else if (in_cfg)                             kind_o = K_CFG;
    else if (in_ack && !we_i && size_i == 3'd1)  kind_o = K_ACK;
    else                                         kind_o = K_ERR;
  end
endmodule

// File: rtl/hbio_irq_swizzle.sv
module hbio_irq_swizzle #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_PINS  = 4,
  parameter int NUM_LINES = 2
) (
  input  logic [NUM_SLOTS*NUM_PINS-1:0] pin_i,
  output logic [NUM_LINES-1:0]          line_o
);
  logic [NUM_LINES-1:0] part [NUM_SLOTS*NUM_PINS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int IDX  = s * NUM_PINS + p;
      localparam int LINE = (p + s) % NUM_LINES;
      if (IDX == 0) begin : g_first
        always_comb begin
          part[IDX]       = '0;
          part[IDX][LINE] = pin_i[IDX];
        end
      end else begin : g_rest
        always_comb begin
          part[IDX]       = part[IDX-1];
          part[IDX][LINE] = part[IDX-1][LINE] | pin_i[IDX];
        end
      end
    end
  end

  assign line_o = part[NUM_SLOTS*NUM_PINS-1];

  always_comb begin
    assert_quiet_R12: assert (|pin_i || line_o == '0);
  end
endmodule

// File: rtl/hbio_bridge.sv
module hbio_bridge
  import hbio_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          PORT_W      = 16,
  parameter int          CFG_SPAN_L2 = 22,
  parameter int          VEC_W       = 8,
  parameter int          NUM_SLOTS   = 4,
  parameter int          NUM_PINS    = 4,
  parameter int          NUM_LINES   = 2,
  parameter logic [15:0] MODE_PORT   = 16'h0850
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cpu_valid_i,
  output logic                          cpu_ready_o,
  input  logic [ADDR_W-1:0]             cpu_addr_i,
  input  logic [2:0]                    cpu_size_i,
  input  logic                          cpu_we_i,
  input  logic [DATA_W-1:0]             cpu_wdata_i,
  output logic                          cpu_resp_o,
  output logic                          cpu_err_o,
  output logic [DATA_W-1:0]             cpu_rdata_o,
  output logic                          io_valid_o,
  input  logic                          io_ready_i,
  output logic [ADDR_W-1:0]             io_addr_o,
  input  logic [DATA_W-1:0]             io_rdata_i,
  output logic                          cfg_valid_o,
  input  logic                          cfg_ready_i,
  output logic [CFG_SPAN_L2-1:0]        cfg_addr_o,
  input  logic [DATA_W-1:0]             cfg_rdata_i,
  output logic [2:0]                    dn_size_o,
  output logic                          dn_we_o,
  output logic [DATA_W-1:0]             dn_wdata_o,
  input  logic [VEC_W-1:0]              intack_vec_i,
  output logic                          intack_ack_o,
  input  logic                          sys_wr_i,
  input  logic [PORT_W-1:0]             sys_port_i,
  input  logic [7:0]                    sys_wdata_i,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] pci_int_i,
  output logic [NUM_LINES-1:0]          irq_o
);
  logic                   mode;
  kind_e                  kind;
  logic [ADDR_W-1:0]      xl_addr;
  logic [CFG_SPAN_L2-1:0] xl_cfg;
  state_e                 state_q;
  logic [ADDR_W-1:0]      io_addr_q;
  logic [CFG_SPAN_L2-1:0] cfg_off_q;
  logic [2:0]             size_q;
  logic                   we_q, err_q, ack_q;
  logic [DATA_W-1:0]      wdata_q, rdata_q;
  logic                   accept;

  hbio_mode_reg #(.PORT_W(PORT_W), .MODE_PORT(MODE_PORT)) u_mode (
    .clk_i, .rst_ni, .sys_wr_i, .sys_port_i, .sys_wdata_i, .mode_o(mode)
  );

  hbio_decode #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .CFG_SPAN_L2(CFG_SPAN_L2)) u_dec (
    .addr_i(cpu_addr_i), .size_i(cpu_size_i), .we_i(cpu_we_i), .mode_i(mode),
    .kind_o(kind), .io_addr_o(xl_addr), .cfg_off_o(xl_cfg)
  );

  hbio_irq_swizzle #(.NUM_SLOTS(NUM_SLOTS), .NUM_PINS(NUM_PINS),
                     .NUM_LINES(NUM_LINES)) u_swz (
    .pin_i(pci_int_i), .line_o(irq_o)
  );

  function automatic logic [DATA_W-1:0] lane_mask(input logic [DATA_W-1:0] d,
                                                  input logic [2:0] sz);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W/8; b++)
      if (b < int'(sz)) m[b*8 +: 8] = 8'hFF;
    return d & m;
  endfunction

  assign accept = cpu_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      io_addr_q <= '0;
      cfg_off_q <= '0;
      size_q    <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      err_q     <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          size_q  <= cpu_size_i;
          we_q    <= cpu_we_i;
          wdata_q <= cpu_wdata_i;
          err_q   <= 1'b0;
          rdata_q <= '0;
          unique case (kind)
            K_IO:  begin io_addr_q <= xl_addr; state_q <= ST_IO;  end
            K_CFG: begin cfg_off_q <= xl_cfg;  state_q <= ST_CFG; end
            K_ACK: begin
              rdata_q <= DATA_W'(intack_vec_i);
              ack_q   <= 1'b1;
              state_q <= ST_RESP;
            end
            default: begin err_q <= 1'b1; state_q <= ST_RESP; end
          endcase
        end
        ST_IO: if (io_ready_i) begin
          rdata_q <= we_q ? '0 : lane_mask(io_rdata_i, size_q);
          state_q <= ST_RESP;
        end
        ST_CFG: if (cfg_ready_i) begin
          rdata_q <= we_q ? '0 : lane_mask(cfg_rdata_i, size_q);
          state_q <= ST_RESP;
        end
        default: begin
          ack_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign cpu_ready_o  = state_q == ST_IDLE;
  assign cpu_resp_o   = state_q == ST_RESP;
  assign cpu_err_o    = cpu_resp_o && err_q;
  assign cpu_rdata_o  = rdata_q;
  assign io_valid_o   = state_q == ST_IO;
  assign io_addr_o    = io_addr_q;
  assign cfg_valid_o  = state_q == ST_CFG;
  assign cfg_addr_o   = cfg_off_q;
  assign dn_size_o    = size_q;
  assign dn_we_o      = we_q;
  assign dn_wdata_o   = wdata_q;
  assign intack_ack_o = cpu_resp_o && ack_q;

  assert_one_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_valid_o, cfg_valid_o, cpu_resp_o, cpu_ready_o}));
  assert_io_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o && !io_ready_i |=> io_valid_o && $stable(io_addr_o) && $stable(dn_wdata_o));
  assert_cfg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && !cfg_ready_i |=> cfg_valid_o && $stable(cfg_addr_o));
  assert_io_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o && io_ready_i |=> cpu_resp_o && !io_valid_o);
  assert_bad_size_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i && cpu_ready_o &&
    !(cpu_size_i == 3'd1 || cpu_size_i == 3'd2 || cpu_size_i == 3'd4)
    |=> cpu_resp_o && cpu_err_o && !io_valid_o && !cfg_valid_o);
  assert_io_base_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_o |-> io_addr_o[ADDR_W-1:PORT_W] == (ADDR_W-PORT_W)'(32'h8000_0000 >> PORT_W));
  assert_ack_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intack_ack_o |-> cpu_resp_o && !cpu_err_o && !dn_we_o);
endmodule

// File: tb/sim_hbio_bridge.sv
`timescale 1ns/1ps
module sim_hbio_bridge;
  logic        clk = 0, rst_ni = 0;
  logic        cpu_valid_i = 0, cpu_ready_o;
  logic [31:0] cpu_addr_i = 0;
  logic [2:0]  cpu_size_i = 0;
  logic        cpu_we_i = 0;
  logic [31:0] cpu_wdata_i = 0;
  logic        cpu_resp_o, cpu_err_o;
  logic [31:0] cpu_rdata_o;
  logic        io_valid_o, io_ready_i = 0;
  logic [31:0] io_addr_o, io_rdata_i = 0;
  logic        cfg_valid_o, cfg_ready_i = 0;
  logic [21:0] cfg_addr_o;
  logic [31:0] cfg_rdata_i = 0;
  logic [2:0]  dn_size_o;
  logic        dn_we_o;
  logic [31:0] dn_wdata_o;
  logic [7:0]  intack_vec_i = 0;
  logic        intack_ack_o;
  logic        sys_wr_i = 0;
  logic [15:0] sys_port_i = 0;
  logic [7:0]  sys_wdata_i = 0;
  logic [15:0] pci_int_i = 0;
  logic [1:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int io_lat = 0, io_wait = 0, io_n = 0;
  int cfg_lat = 0, cfg_wait = 0, cfg_n = 0;
  logic [31:0] io_last_addr, io_last_wdata;
  logic [2:0]  io_last_size;
  logic [21:0] cfg_last_addr;
  logic        ack_seen;

  always #10 clk = ~clk;

  hbio_bridge u0 (.*, .clk_i(clk));

  // downstream responders: one ready pulse per request after io_lat waits
  initial forever begin
    @(negedge clk);
    if (io_ready_i) io_ready_i = 0;
    else if (io_valid_o) begin
      if (io_wait == io_lat) begin
        io_ready_i = 1; io_wait = 0; io_n++;
        io_last_addr = io_addr_o; io_last_size = dn_size_o; io_last_wdata = dn_wdata_o;
      end else io_wait++;
    end
    if (cfg_ready_i) cfg_ready_i = 0;
    else if (cfg_valid_o) begin
      if (cfg_wait == cfg_lat) begin
        cfg_ready_i = 1; cfg_wait = 0; cfg_n++; cfg_last_addr = cfg_addr_o;
      end else cfg_wait++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [2:0] sz, input logic we,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er, output int cyc);
    @(negedge clk);
    cpu_valid_i = 1; cpu_addr_i = a; cpu_size_i = sz; cpu_we_i = we; cpu_wdata_i = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_valid_i = 0;
    cyc = 1;
    while (!cpu_resp_o) begin @(negedge clk); cyc++; end
    rd = cpu_rdata_o; er = cpu_err_o; ack_seen = intack_ack_o;
  endtask

  task automatic sys_write(input logic [15:0] p, input logic [7:0] d);
    @(negedge clk);
    sys_wr_i = 1; sys_port_i = p; sys_wdata_i = d;
    @(negedge clk);
    sys_wr_i = 0;
  endtask

  function automatic logic [31:0] sparse(input logic [31:0] a);
    return 32'h8000_0000 | (((a >> 12) & 32'h7FF) << 5) | (a & 32'h1F);
  endfunction

  task automatic t_reset;
    chk(cpu_ready_o === 1'b1, "R1 ready", {31'd0, cpu_ready_o}, 1);
    chk({io_valid_o, cfg_valid_o, cpu_resp_o} === 3'b000, "R1 idle",
        {29'd0, io_valid_o, cfg_valid_o, cpu_resp_o}, 0);
  endtask

  task automatic t_flat;
    logic [31:0] rd; logic er; int c, n0;
    n0 = io_n;
    access(32'h8012_3456, 3'd4, 1'b1, 32'hCAFE_F00D, rd, er, c);
    chk(io_last_addr == 32'h8000_3456, "R2 flat addr", io_last_addr, 32'h8000_3456);
    chk(io_n == n0 + 1 && !er, "R11 one txn", io_n - n0, 1);
    chk(io_last_wdata == 32'hCAFE_F00D, "R7 wdata", io_last_wdata, 32'hCAFE_F00D);
  endtask

  task automatic t_sparse;
    logic [31:0] rd; logic er; int c;
    sys_write(16'h0850, 8'h01);
    access(32'h8012_3456, 3'd1, 1'b0, 0, rd, er, c);
    chk(io_last_addr == sparse(32'h8012_3456), "R3 sparse addr", io_last_addr,
        sparse(32'h8012_3456));
    access(32'h807F_F01F, 3'd1, 1'b0, 0, rd, er, c);
    chk(io_last_addr == 32'h8000_FFFF, "R3 sparse top", io_last_addr, 32'h8000_FFFF);
    sys_write(16'h0851, 8'h00);
    access(32'h8000_3021, 3'd1, 1'b0, 0, rd, er, c);
    chk(io_last_addr == sparse(32'h8000_3021), "R4 other port ignored", io_last_addr,
        sparse(32'h8000_3021));
    sys_write(16'h0850, 8'hFE);
    access(32'h8000_3021, 3'd1, 1'b0, 0, rd, er, c);
    chk(io_last_addr == 32'h8000_3021, "R4 bit0 clears", io_last_addr, 32'h8000_3021);
  endtask

  task automatic t_inflight;
    logic [31:0] rd; logic er; int c;
    io_lat = 3;
    fork
      access(32'h8001_2345, 3'd2, 1'b0, 0, rd, er, c);
      begin repeat (2) @(negedge clk); sys_write(16'h0850, 8'h01); end
    join
    chk(io_last_addr == 32'h8000_2345, "R5 in-flight keeps flat", io_last_addr,
        32'h8000_2345);
    io_lat = 0;
    access(32'h8001_2345, 3'd2, 1'b0, 0, rd, er, c);
    chk(io_last_addr == sparse(32'h8001_2345), "R5 next uses sparse", io_last_addr,
        sparse(32'h8001_2345));
    sys_write(16'h0850, 8'h00);
  endtask

  task automatic t_sizes;
    logic [31:0] rd; logic er; int c, n0;
    access(32'h8000_0103, 3'd2, 1'b1, 32'h0000_BEEF, rd, er, c);
    chk(!er && io_last_addr == 32'h8000_0103 && io_last_size == 3'd2,
        "R6 unaligned 2B", io_last_addr, 32'h8000_0103);
    n0 = io_n;
    access(32'h8000_0100, 3'd3, 1'b1, 0, rd, er, c);
    chk(er && io_n == n0 && cfg_n == cfg_n, "R6 size 3 error", {31'd0, er}, 1);
    access(32'h8000_0100, 3'd0, 1'b0, 0, rd, er, c);
    chk(er && io_n == n0, "R6 size 0 error", io_n - n0, 0);
  endtask

  task automatic t_rdata;
    logic [31:0] rd; logic er; int c;
    io_rdata_i = 32'hA1B2_C3D4;
    access(32'h8000_0060, 3'd1, 1'b0, 0, rd, er, c);
    chk(rd == 32'h0000_00D4, "R7 byte read", rd, 32'h0000_00D4);
    access(32'h8000_0060, 3'd2, 1'b0, 0, rd, er, c);
    chk(rd == 32'h0000_C3D4, "R7 half read", rd, 32'h0000_C3D4);
    access(32'h8000_0060, 3'd4, 1'b0, 0, rd, er, c);
    chk(rd == 32'hA1B2_C3D4, "R7 word read", rd, 32'hA1B2_C3D4);
  endtask

  task automatic t_cfg;
    logic [31:0] rd; logic er; int c, n0;
    n0 = io_n;
    cfg_rdata_i = 32'h1234_5678; cfg_lat = 1;
    access(32'h80A1_2344, 3'd4, 1'b0, 0, rd, er, c);
    chk(cfg_last_addr == 22'h21_2344 && io_n == n0, "R8 cfg offset",
        {10'd0, cfg_last_addr}, 32'h0021_2344);
    chk(rd == 32'h1234_5678 && c == 3, "R8 cfg data", rd, 32'h1234_5678);
    cfg_lat = 0;
  endtask

  task automatic t_intack;
    logic [31:0] rd; logic er; int c;
    intack_vec_i = 8'h9C;
    access(32'hBFFF_FFF0, 3'd1, 1'b0, 0, rd, er, c);
    chk(rd == 32'h9C && !er && ack_seen, "R9 vector", rd, 32'h9C);
    access(32'hBFFF_FFF0, 3'd2, 1'b0, 0, rd, er, c);
    chk(er && !ack_seen, "R9 wide error", {31'd0, er}, 1);
    access(32'hBFFF_FFF0, 3'd1, 1'b1, 0, rd, er, c);
    chk(er && !ack_seen, "R9 write error", {31'd0, er}, 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] rd; logic er; int c, n0, m0;
    n0 = io_n; m0 = cfg_n;
    access(32'h80C0_0000, 3'd4, 1'b0, 0, rd, er, c);
    chk(er && io_n == n0 && cfg_n == m0 && c == 1, "R10 unmapped", {31'd0, er}, 1);
    access(32'h7FFF_FFFF, 3'd1, 1'b0, 0, rd, er, c);
    chk(er && io_n == n0, "R10 below window", {31'd0, er}, 1);
  endtask

  task automatic t_latency;
    logic [31:0] rd; logic er; int c, n0;
    n0 = io_n; io_lat = 4;
    access(32'h8000_0010, 3'd4, 1'b0, 0, rd, er, c);
    chk(c == 6 && io_n == n0 + 1, "R11 latency", c, 6);
    io_lat = 0;
    access(32'h8000_0010, 3'd4, 1'b0, 0, rd, er, c);
    chk(c == 2, "R11 zero wait", c, 2);
  endtask

  task automatic t_irq;
    pci_int_i = 16'h0010; #1;
    chk(irq_o == 2'b10, "R12 slot1 A", {30'd0, irq_o}, 2);
    pci_int_i = 16'h0200; #1;
    chk(irq_o == 2'b10, "R12 slot2 B", {30'd0, irq_o}, 2);
    pci_int_i = 16'h8004; #1;
    chk(irq_o == 2'b01, "R12 slot0 C slot3 D", {30'd0, irq_o}, 1);
    pci_int_i = 16'h0000; #1;
    chk(irq_o == 2'b00, "R12 quiet", {30'd0, irq_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1;
    @(negedge clk);
    t_reset;
    t_flat;
    t_sparse;
    t_inflight;
    t_sizes;
    t_rdata;
    t_cfg;
    t_intack;
    t_unmapped;
    t_latency;
    t_irq;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule